// File: doc/BRIEF.md
# ADC Conversion Cycle Sequencer

This block paces a single analog-to-digital conversion inside a multiplexed acquisition front end. It divides the core clock by a programmable factor to form a conversion clock, and every conversion occupies a fixed frame of 48 periods of that clock. The frame opens with an amplifier phase, which is split into capture, auto-zero and amplify sub-phases. A successive-approximation phase follows, resolving one result bit per period. The block drives one enable strobe per phase, the index of the result bit being decided, a BUSY level and a one-cycle completion pulse.

A conversion can be requested in four ways: a direct command strobe, either of two register-write strobes that carry a convert flag, or an external CONVERT pin. The pin is edge-sensitive and is qualified over two core-clock edges before it counts. Requests that arrive while a conversion runs are merged into a single pending request, and that conversion starts as soon as the current frame closes. Reset and oscillator enable each come from a pin input and a command input, combined with a logical OR. The analog circuits, the bit-decision logic, the serial port and the register file lie outside the block and appear only as strobes.

Top module: `adc_conv_seq`

## Requirements
- R1: The effective division factor is `div_i`, or 1 when `div_i` is 0. While busy and clocked, each conversion period lasts that many core cycles. `cclk_tick_o` is high in the last core cycle of each period and is low whenever `busy_o` is low.
- R2: An isolated conversion raises `busy_o` on the clock edge that samples the request and holds it for exactly 48 periods, i.e. 48 × factor core cycles when the oscillator stays enabled.
- R3: While busy, exactly one enable is high: `cap_en_o` in periods 0–11, `az_en_o` in 12–23, `amp_en_o` in 24–35 and `sar_en_o` in 36–47. While idle, all four are low.
- R4: `sar_bit_o` reads 11 in period 36 and counts down by one per period, reaching 0 in period 47. It reads 0 outside the successive-approximation phase.
- R5: `done_o` is high for exactly one core cycle, the last busy cycle of a frame. In that cycle `sar_en_o` is high and `sar_bit_o` is 0.
- R6: Any of `direct_cnv_i`, `wr_cfg_a_cnv_i`, `wr_cfg_b_cnv_i` or a qualified pin event starts a conversion (logical OR).
- R7: Requests made while busy, including one in the `done_o` cycle, set a single pending request. The next frame then follows with no idle cycle, and any number of requests in one frame yields only one extra conversion.
- R8: When `convert_pin_i` is high at two consecutive core edges, `busy_o` rises at the second edge. A high lasting one edge is ignored, and a long high gives one conversion only.
- R9: The oscillator runs when `osc_en_pin_i` or `osc_en_cmd_i` is high. When both are low, period counting halts with `busy_o` held, and it resumes where it stopped.
- R10: Either `rst_pin_i` or `rst_cmd_i` high at a clock edge synchronously clears busy, pending, counters and the pin history. All outputs then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_pin_i | input | 1 | Reset from pin, synchronous, active high |
| rst_cmd_i | input | 1 | Reset from command bit, synchronous, active high |
| osc_en_pin_i | input | 1 | Oscillator enable from pin |
| osc_en_cmd_i | input | 1 | Oscillator enable from command bit |
| div_i | input | DIV_W (8) | Conversion-clock division factor, 0 treated as 1 |
| direct_cnv_i | input | 1 | Direct-mode convert strobe |
| wr_cfg_a_cnv_i | input | 1 | First register-write convert strobe |
| wr_cfg_b_cnv_i | input | 1 | Second register-write convert strobe |
| convert_pin_i | input | 1 | External convert pin, asynchronous level |
| busy_o | output | 1 | Conversion in progress |
| cclk_tick_o | output | 1 | Last core cycle of a conversion period |
| cap_en_o | output | 1 | Input-capture sub-phase enable |
| az_en_o | output | 1 | Auto-zero sub-phase enable |
| amp_en_o | output | 1 | Level-shift and amplify sub-phase enable |
| sar_en_o | output | 1 | Successive-approximation phase enable |
| sar_bit_o | output | 4 | Index of result bit being resolved |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets a request landing in the very cycle `done_o` is high. A design that only samples requests while mid-frame would drop that request or insert an idle cycle before the next frame. It drives several requests into one frame, which catches a counter-based queue that runs extra conversions, and a one-cycle pin pulse, which an unqualified pin would turn into a spurious conversion. It also stops the oscillator mid-frame and uses division factor zero. A design that kept counting while the oscillator was off would end the frame early, and one that took zero literally would never tick.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_AUTOZERO = 2'd1,
    PH_AMPLIFY = 2'd2,
    PH_SAR = 2'd3
  } phase_e;

  // Period index to phase, given the sub-phase lengths.
  function automatic phase_e phase_of(int per, int cap_len, int az_len, int amp_len);
    if (per < cap_len) return PH_CAPTURE;
    if (per < cap_len + az_len) return PH_AUTOZERO;
    if (per < cap_len + az_len + amp_len) return PH_AMPLIFY;
    return PH_SAR;
  endfunction

  // Bit under decision: highest bit first, last period resolves bit 0.
  function automatic int sar_index(int per, int frame_len);
    return frame_len - 1 - per;
  endfunction

  // Division factor zero behaves as one; returns factor minus one.
  function automatic int div_minus_one(int d);
    return (d == 0) ? 0 : d - 1;
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             busy_i,
  input  logic             osc_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  import adc_seq_pkg::*;

  logic [DIV_W-1:0] sub_cnt;
  logic [DIV_W-1:0] last_sub;
  logic             run;

  assign run      = busy_i && osc_en_i;
  assign last_sub = DIV_W'(div_minus_one(int'(div_i)));
  assign tick_o   = run && (sub_cnt >= last_sub);

  always_ff @(posedge clk_i) begin
    if (rst_i || !busy_i) begin
      sub_cnt <= '0;
    end else if (run) begin
      sub_cnt <= tick_o ? '0 : sub_cnt + 1'b1;
    end
  end

  p_no_tick_idle_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_i |-> !tick_o);
  p_no_tick_osc_off_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !osc_en_i |-> !tick_o);
  p_sub_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && !osc_en_i) |=> (!busy_i || $stable(sub_cnt)));

endmodule

// File: rtl/adc_start_arb.sv
module adc_start_arb (
  input  logic clk_i,
  input  logic rst_i,
  input  logic direct_i,
  input  logic wr_a_i,
  input  logic wr_b_i,
  input  logic pin_i,
  input  logic frame_end_i,
  output logic busy_o,
  output logic pending_o,
  output logic pin_fire_o,
  output logic start_o
);
  logic pin_d1;
  logic pin_d2;
  logic any_req;
  logic busy_nx;
  logic pend_nx;

  // Pin counts when high now and at the previous edge, but not two edges back.
  assign pin_fire_o = pin_i && pin_d1 && !pin_d2;
  assign any_req    = direct_i || wr_a_i || wr_b_i || pin_fire_o;
  assign start_o    = (!busy_o && any_req) || (frame_end_i && (pending_o || any_req));

  always_comb begin
    busy_nx = busy_o;
    pend_nx = pending_o;
    if (busy_o) begin
      if (frame_end_i) begin
        busy_nx = pending_o || any_req;
        pend_nx = 1'b0;
      end else begin
        pend_nx = pending_o || any_req;
      end
    end else begin
      busy_nx = any_req;
      pend_nx = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_o    <= 1'b0;
      pending_o <= 1'b0;
      pin_d1    <= 1'b0;
      pin_d2    <= 1'b0;
    end else begin
      busy_o    <= busy_nx;
      pending_o <= pend_nx;
      pin_d1    <= pin_i;
      pin_d2    <= pin_d1;
    end
  end

  p_pend_needs_busy_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    pending_o |-> busy_o);
  p_pend_drains_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (frame_end_i && pending_o) |=> (busy_o && !pending_o));
  p_pin_two_edges_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    pin_fire_o |-> $past(pin_i));
  p_idle_start_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && (direct_i || wr_a_i || wr_b_i)) |=> busy_o);

endmodule

// File: rtl/adc_frame_ctr.sv
module adc_frame_ctr #(
  parameter int CAP_LEN  = 12,
  parameter int AZ_LEN   = 12,
  parameter int AMP_LEN  = 12,
  parameter int SAR_BITS = 12,
  parameter int SBW      = $clog2(SAR_BITS)
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           busy_i,
  input  logic           tick_i,
  output logic           cap_en_o,
  output logic           az_en_o,
  output logic           amp_en_o,
  output logic           sar_en_o,
  output logic [SBW-1:0] sar_bit_o,
  output logic           frame_end_o
);
  import adc_seq_pkg::*;

  localparam int FRAME = CAP_LEN + AZ_LEN + AMP_LEN + SAR_BITS;
  localparam int PER_W = $clog2(FRAME);
  localparam logic [PER_W-1:0] LAST_PER = PER_W'(FRAME - 1);

  logic [PER_W-1:0] per_cnt;
  phase_e           phase;

  assign phase       = phase_of(int'(per_cnt), CAP_LEN, AZ_LEN, AMP_LEN);
  assign cap_en_o    = busy_i && (phase == PH_CAPTURE);
  assign az_en_o     = busy_i && (phase == PH_AUTOZERO);
  assign amp_en_o    = busy_i && (phase == PH_AMPLIFY);
  assign sar_en_o    = busy_i && (phase == PH_SAR);
  assign sar_bit_o   = sar_en_o ? SBW'(sar_index(int'(per_cnt), FRAME)) : '0;
  assign frame_end_o = busy_i && tick_i && (per_cnt == LAST_PER);

  always_ff @(posedge clk_i) begin
    if (rst_i || !busy_i) begin
      per_cnt <= '0;
    end else if (tick_i) begin
      per_cnt <= (per_cnt == LAST_PER) ? '0 : per_cnt + 1'b1;
    end
  end

  p_one_phase_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_i |-> ($countones({cap_en_o, az_en_o, amp_en_o, sar_en_o}) == 1));
  p_quiet_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_i |-> ({cap_en_o, az_en_o, amp_en_o, sar_en_o} == 4'b0000));
  p_bit_steps_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (sar_en_o && tick_i && !frame_end_o) |=> (sar_bit_o == $past(sar_bit_o) - 1'b1));
  p_done_bit0_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_end_o |-> (sar_en_o && sar_bit_o == '0));
  p_per_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && !tick_i) |=> (!busy_i || $stable(per_cnt)));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DIV_W    = 8,
  parameter int CAP_LEN  = 12,
  parameter int AZ_LEN   = 12,
  parameter int AMP_LEN  = 12,
  parameter int SAR_BITS = 12,
  parameter int SBW      = $clog2(SAR_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_pin_i,
  input  logic             rst_cmd_i,
  input  logic             osc_en_pin_i,
  input  logic             osc_en_cmd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             direct_cnv_i,
  input  logic             wr_cfg_a_cnv_i,
  input  logic             wr_cfg_b_cnv_i,
  input  logic             convert_pin_i,
  output logic             busy_o,
  output logic             cclk_tick_o,
  output logic             cap_en_o,
  output logic             az_en_o,
  output logic             amp_en_o,
  output logic             sar_en_o,
  output logic [SBW-1:0]   sar_bit_o,
  output logic             done_o
);
  // Named internal events, visible to assertions.
  logic rst_any;
  logic osc_on;
  logic busy;
  logic pending;
  logic pin_fire;
  logic start;
  logic tick;
  logic frame_end;

  assign rst_any = rst_pin_i || rst_cmd_i;
  assign osc_on  = osc_en_pin_i || osc_en_cmd_i;

  adc_start_arb u_arb (
    .clk_i       (clk_i),
    .rst_i       (rst_any),
    .direct_i    (direct_cnv_i),
    .wr_a_i      (wr_cfg_a_cnv_i),
    .wr_b_i      (wr_cfg_b_cnv_i),
    .pin_i       (convert_pin_i),
    .frame_end_i (frame_end),
    .busy_o      (busy),
    .pending_o   (pending),
    .pin_fire_o  (pin_fire),
    .start_o     (start)
  );

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_i    (rst_any),
    .busy_i   (busy),
    .osc_en_i (osc_on),
    .div_i    (div_i),
    .tick_o   (tick)
  );

  adc_frame_ctr #(
    .CAP_LEN  (CAP_LEN),
    .AZ_LEN   (AZ_LEN),
    .AMP_LEN  (AMP_LEN),
    .SAR_BITS (SAR_BITS),
    .SBW      (SBW)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_i       (rst_any),
    .busy_i      (busy),
    .tick_i      (tick),
    .cap_en_o    (cap_en_o),
    .az_en_o     (az_en_o),
    .amp_en_o    (amp_en_o),
    .sar_en_o    (sar_en_o),
    .sar_bit_o   (sar_bit_o),
    .frame_end_o (frame_end)
  );

  assign busy_o      = busy;
  assign cclk_tick_o = tick;
  assign done_o      = frame_end;

  p_reset_clears_r10: assert property (@(posedge clk_i)
    rst_any |=> (!busy_o && !pending));
  p_busy_ends_done_r2: assert property (@(posedge clk_i) disable iff (rst_any)
    ($fell(busy_o) && !$past(rst_any)) |-> $past(done_o));
  p_start_sets_busy_r6: assert property (@(posedge clk_i) disable iff (rst_any)
    start |=> busy_o);
  p_pin_starts_r8: assert property (@(posedge clk_i) disable iff (rst_any)
    (pin_fire && !busy_o) |=> busy_o);

endmodule

// File: tb/adc_conv_seq_tb_top.sv
`timescale 1ns/1ps
module adc_conv_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_pin = 1'b1, rst_cmd = 1'b0;
  logic       osc_pin = 1'b0, osc_cmd = 1'b0;
  logic [7:0] div = 8'd1;
  logic       direct = 1'b0, wr_a = 1'b0, wr_b = 1'b0, pin = 1'b0;
  logic       busy, tick, cap, az, amp, sar, done;
  logic [3:0] sbit;

  always #2 clk = ~clk;

  adc_conv_seq dut_i (
    .clk_i(clk), .rst_pin_i(rst_pin), .rst_cmd_i(rst_cmd),
    .osc_en_pin_i(osc_pin), .osc_en_cmd_i(osc_cmd), .div_i(div),
    .direct_cnv_i(direct), .wr_cfg_a_cnv_i(wr_a), .wr_cfg_b_cnv_i(wr_b),
    .convert_pin_i(pin), .busy_o(busy), .cclk_tick_o(tick),
    .cap_en_o(cap), .az_en_o(az), .amp_en_o(amp), .sar_en_o(sar),
    .sar_bit_o(sbit), .done_o(done)
  );

  int n_cmp = 0, n_bad = 0, n_done = 0, cyc = 0;
  bit finished = 0;

  // Behavioural reference: elapsed clocked core cycles in the frame.
  bit m_busy = 0, m_pend = 0, h1 = 0, h2 = 0;
  int m_el = 0;

  function automatic int eff();
    return (div == 0) ? 1 : int'(div);
  endfunction

  task automatic cmp(string nm, string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int per, e, ex_tick, ex_done;
    if (!finished) begin
      e = eff();
      per = m_el / e;
      ex_tick = (m_busy && (osc_pin || osc_cmd) && (m_el % e) == e - 1) ? 1 : 0;
      ex_done = (ex_tick && per == 47) ? 1 : 0;
      cmp("busy", "R2", busy, m_busy);
      cmp("tick", "R1", tick, ex_tick);
      cmp("cap", "R3", cap, m_busy && per < 12);
      cmp("az", "R3", az, m_busy && per >= 12 && per < 24);
      cmp("amp", "R3", amp, m_busy && per >= 24 && per < 36);
      cmp("sar", "R3", sar, m_busy && per >= 36);
      cmp("sar_bit", "R4", sbit, (m_busy && per >= 36) ? 47 - per : 0);
      cmp("done", "R5", done, ex_done);
      if (done) n_done++;
    end
  end

  always @(posedge clk) begin
    bit req, fire, osc, fin;
    int e;
    cyc++;
    if (rst_pin || rst_cmd) begin
      m_busy = 0; m_pend = 0; m_el = 0; h1 = 0; h2 = 0;
    end else begin
      e = eff();
      osc = osc_pin || osc_cmd;
      fire = pin && h1 && !h2;
      req = direct || wr_a || wr_b || fire;
      fin = m_busy && osc && (m_el % e) == e - 1 && (m_el / e) == 47;
      if (m_busy) begin
        if (fin) begin
          m_busy = m_pend || req; m_pend = 0; m_el = 0;
        end else begin
          if (osc) m_el++;
          m_pend = m_pend || req;
        end
      end else if (req) begin
        m_busy = 1; m_el = 0;
      end
      h2 = h1; h1 = pin;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    cmp(what, req, act, exp);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    cycles(3);
    chk("R10", "reset busy", busy, 0);
    chk("R10", "reset done", done, 0);
    rst_pin = 0; osc_cmd = 1; div = 8'd1;
    cycles(2);
    // R6 direct strobe, factor 1
    direct = 1; cycles(1); direct = 0;
    chk("R2", "busy after start", busy, 1);
    cycles(60);
    chk("R6", "done count direct", n_done, 1);
    // R6 first write strobe, factor 3
    div = 8'd3; wr_a = 1; cycles(1); wr_a = 0;
    cycles(48 * 3 + 10);
    chk("R6", "done count wr_a", n_done, 2);
    // R1 factor zero acts as one, second write strobe
    div = 8'd0; wr_b = 1; cycles(1); wr_b = 0;
    cycles(48);
    chk("R1", "factor zero frame", n_done, 3);
    cycles(5);
    // R7 several requests in one frame merge into one
    div = 8'd2; direct = 1; cycles(1); direct = 0;
    cycles(10); wr_a = 1; cycles(1); wr_a = 0;
    cycles(5); direct = 1; wr_b = 1; cycles(1); direct = 0; wr_b = 0;
    cycles(2 * 96 + 20);
    chk("R7", "merged queue count", n_done, 5);
    // R7 request in the done cycle
    div = 8'd1; direct = 1; cycles(1); direct = 0;
    while (!done) @(negedge clk);
    wr_b = 1; @(posedge clk); #1 wr_b = 0;
    chk("R7", "back to back busy", busy, 1);
    cycles(60);
    chk("R7", "done-cycle request count", n_done, 7);
    // R8 one-edge pin pulse ignored
    pin = 1; cycles(1); pin = 0; cycles(5);
    chk("R8", "glitch busy", busy, 0);
    // R8 long high gives one conversion
    pin = 1; cycles(150); pin = 0; cycles(5);
    chk("R8", "held pin count", n_done, 8);
    // R9 oscillator off halts, pin enable resumes
    div = 8'd2; direct = 1; cycles(1); direct = 0;
    cycles(20); osc_cmd = 0; cycles(40);
    chk("R9", "stalled busy", busy, 1);
    chk("R9", "stalled count", n_done, 8);
    osc_pin = 1; cycles(100); osc_pin = 0; osc_cmd = 1;
    chk("R9", "resumed count", n_done, 9);
    // R10 command reset mid frame
    direct = 1; cycles(1); direct = 0; cycles(20);
    rst_cmd = 1; cycles(1); rst_cmd = 0;
    chk("R10", "cmd reset busy", busy, 0);
    cycles(60);
    chk("R10", "no done after reset", n_done, 9);
    // Mixed random traffic checked by the model
    for (int i = 0; i < 3000; i++) begin
      if (i % 400 == 0 && !busy) div = 8'($urandom_range(0, 3));
      direct = ($urandom_range(0, 60) == 0);
      wr_a = ($urandom_range(0, 90) == 0);
      pin = ($urandom_range(0, 7) == 0) ? ~pin : pin;
      osc_pin = ($urandom_range(0, 20) == 0);
      if (busy) div = div;
      cycles(1);
    end
    direct = 0; wr_a = 0; pin = 0; osc_pin = 0;
    cycles(400);
    finish_run();
  end

endmodule